// File: doc/BRIEF.md
# Dual-Channel Serial Port Register Front End

This block is the bus-facing register layer for a two-channel asynchronous serial port. A host issues byte-wide reads and writes on a small address space. Each channel owns an eight-address window holding a mode location, a status/clock-select location, a command location and a data-holding location. The block turns command writes into enable, disable, reset and line-break controls. It stores the character format (data length, parity, stop length) and an extended mode byte. It presents the whole status byte and the holding data to the host.

The mode registers all sit behind a single address. A per-channel pointer chooses which one a mode write lands in, and the pointer advances on each write. The command byte combines independent enable/disable bits in its low nibble with a coded command in its high nibble. The shift engines, the baud generator and the FIFOs sit outside the block. Toward them the block drives registered control levels, one-cycle reset and push/pop pulses, and it takes live ready flags, error event pulses and received data.

Top module: `uart_regfront`

## Requirements
- R1: Channel n decodes addresses n*8 + offset. The offsets are mode 0, status/clock-select 1, command 2 and holding 3. Writes to offsets 4 to 7 change no output. Reads of the command offset and of offsets 4 to 7 return 0x00. An access to one channel never changes the other channel's outputs.
- R2: In a command write, bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it. When the enable and disable bits of one direction are both set, the disable wins. After reset both directions are disabled.
- R3: Command code 2 (bits 7:4) gives a one-cycle rx_rst pulse and leaves the receiver disabled. Code 3 does the same for the transmitter through tx_rst. Every other code leaves both pulses low.
- R4: Command code 6 sets brk_on and code 7 clears it. Other codes leave it unchanged.
- R5: Command code 1 points the mode pointer at the first format register, and reset does the same. Successive mode writes load the first format register and then the second. Further writes keep loading the second until a new pointer command arrives. A mode read returns the register under the pointer and does not move the pointer.
- R6: When EXT_MODE is 1, command code 0xB points the pointer at the extended mode byte (ext_cfg). The next writes then load the extended byte, the first format register and the second format register in that order. When EXT_MODE is 0, code 0xB has no effect.
- R7: The first format register resets to 0x13. Its bits 1:0 give data_bits (0 to 3 mean 5 to 8 bits). Its bit 4 set means no parity (par_en low). Otherwise parity is enabled, and bit 2 selects odd (1) or even (0) through par_odd.
- R8: The second format register resets to 0x07. Bit 3 gives stop_two, so 0x07 selects one stop bit and 0x0F selects two.
- R9: The status byte has receive ready at bit 0, FIFO full at bit 1, transmit ready at bit 2 and transmitter empty at bit 3, all taken live from the inputs. Above them sit overrun at bit 4, parity error at bit 5, framing error at bit 6 and received break at bit 7. Each of these upper bits is set by a one-cycle event pulse and stays set.
- R10: Command code 4 clears status bits 7:4 and leaves bits 3:0 intact. An event in the same cycle as the clear leaves its bit set. Code 5 clears brk_chg, which is set by the break-change event pulse.
- R11: A read of the holding offset returns that channel's rx_data and pulses rx_pop for one cycle. A write to it loads tx_data and pulses tx_push for one cycle.
- R12: A write to the status/clock-select offset stores the byte on that channel's clk_sel.
- R13: bus_rdata changes only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address (channel in upper bits) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| st_rx_rdy | input | NUM_CH | Receive data ready flag per channel |
| st_full | input | NUM_CH | Receive FIFO full flag per channel |
| st_tx_rdy | input | NUM_CH | Transmitter can accept data |
| st_tx_emt | input | NUM_CH | Transmitter fully empty |
| ev_ovr | input | NUM_CH | Overrun event pulse |
| ev_par | input | NUM_CH | Parity error event pulse |
| ev_frm | input | NUM_CH | Framing error event pulse |
| ev_brk | input | NUM_CH | Received break event pulse |
| ev_brk_chg | input | NUM_CH | Break change event pulse |
| rx_data | input | 8*NUM_CH | Received character per channel |
| rx_en | output | NUM_CH | Receiver enable |
| tx_en | output | NUM_CH | Transmitter enable |
| rx_rst | output | NUM_CH | Receiver reset pulse |
| tx_rst | output | NUM_CH | Transmitter reset pulse |
| brk_on | output | NUM_CH | Transmit line break active |
| brk_chg | output | NUM_CH | Sticky break-change flag |
| data_bits | output | 2*NUM_CH | Data length code |
| par_en | output | NUM_CH | Parity enabled |
| par_odd | output | NUM_CH | Odd parity select |
| stop_two | output | NUM_CH | Two stop bits |
| ext_cfg | output | 8*NUM_CH | Extended mode byte |
| clk_sel | output | 8*NUM_CH | Clock-select byte |
| tx_data | output | 8*NUM_CH | Transmit character |
| tx_push | output | NUM_CH | Transmit load pulse |
| rx_pop | output | NUM_CH | Receive consume pulse |

## Verification
The assertions assume that the host raises at most one of bus_we and bus_re in any cycle, that both are low while rst is high, and that event inputs are single-cycle pulses. The bench drives every strobe for exactly one cycle from the falling edge, and it never overlaps a read with a write. It holds all strobes and events low through reset. Apart from the one test that deliberately places an event in the same cycle as a clear command, it pulses events only between bus accesses.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = 3;

  localparam logic [OFF_W-1:0] OFF_MODE = 3'd0;
  localparam logic [OFF_W-1:0] OFF_STAT = 3'd1;
  localparam logic [OFF_W-1:0] OFF_CMD  = 3'd2;
  localparam logic [OFF_W-1:0] OFF_HOLD = 3'd3;

  typedef enum logic [3:0] {
    CMD_NOP       = 4'h0,
    CMD_PTR_FMT   = 4'h1,
    CMD_RX_RST    = 4'h2,
    CMD_TX_RST    = 4'h3,
    CMD_CLR_ERR   = 4'h4,
    CMD_CLR_BCHG  = 4'h5,
    CMD_BRK_ON    = 4'h6,
    CMD_BRK_OFF   = 4'h7,
    CMD_PTR_EXT   = 4'hB
  } cmd_code_e;

  typedef enum logic [1:0] {
    PTR_EXT  = 2'd0,
    PTR_FMT1 = 2'd1,
    PTR_FMT2 = 2'd2
  } mode_ptr_e;

  localparam logic [BYTE_W-1:0] FMT1_RESET = 8'h13;
  localparam logic [BYTE_W-1:0] FMT2_RESET = 8'h07;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
    logic ovr;
  } sticky_t;
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode import uart_rf_pkg::*; #(
  parameter int NUM_CH = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + OFF_W
) (
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_CH-1:0] wr_mode,
  output logic [NUM_CH-1:0] wr_stat,
  output logic [NUM_CH-1:0] wr_cmd,
  output logic [NUM_CH-1:0] wr_hold,
  output logic [NUM_CH-1:0] rd_hold
);
  logic [CH_W-1:0]  ch_field;
  logic [OFF_W-1:0] off_field;

  assign ch_field  = bus_addr[ADDR_W-1:OFF_W];
  assign off_field = bus_addr[OFF_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    logic hit;
    assign hit        = (ch_field == CH_W'(c));
    assign wr_mode[c] = bus_we && hit && (off_field == OFF_MODE);
    assign wr_stat[c] = bus_we && hit && (off_field == OFF_STAT);
    assign wr_cmd[c]  = bus_we && hit && (off_field == OFF_CMD);
    assign wr_hold[c] = bus_we && hit && (off_field == OFF_HOLD);
    assign rd_hold[c] = bus_re && hit && (off_field == OFF_HOLD);
  end
endmodule

// File: rtl/uart_rf_chan.sv
module uart_rf_chan import uart_rf_pkg::*; #(
  parameter bit EXT_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_mode,
  input  logic              wr_stat,
  input  logic              wr_cmd,
  input  logic              wr_hold,
  input  logic              rd_hold,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              st_rx_rdy,
  input  logic              st_full,
  input  logic              st_tx_rdy,
  input  logic              st_tx_emt,
  input  logic              ev_ovr,
  input  logic              ev_par,
  input  logic              ev_frm,
  input  logic              ev_brk,
  input  logic              ev_brk_chg,
  output logic              rx_en,
  output logic              tx_en,
  output logic              rx_rst,
  output logic              tx_rst,
  output logic              brk_on,
  output logic              brk_chg,
  output logic [1:0]        data_bits,
  output logic              par_en,
  output logic              par_odd,
  output logic              stop_two,
  output logic [BYTE_W-1:0] ext_cfg,
  output logic [BYTE_W-1:0] clk_sel,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_push,
  output logic              rx_pop,
  output logic [BYTE_W-1:0] stat_byte,
  output logic [BYTE_W-1:0] mode_view
);
  logic [3:0]        nib;
  logic [BYTE_W-1:0] fmt1_q, fmt2_q;
  mode_ptr_e         ptr_q;
  sticky_t           sticky_q, sticky_set;
  logic              clr_err, clr_bchg, ptr_to_fmt, ptr_to_ext;

  assign nib        = wdata[7:4];
  assign clr_err    = wr_cmd && (nib == CMD_CLR_ERR);
  assign clr_bchg   = wr_cmd && (nib == CMD_CLR_BCHG);
  assign ptr_to_fmt = wr_cmd && (nib == CMD_PTR_FMT);
  assign ptr_to_ext = EXT_MODE && wr_cmd && (nib == CMD_PTR_EXT);
  assign sticky_set = '{brk: ev_brk, frm: ev_frm, par: ev_par, ovr: ev_ovr};

  // live flags low, sticky errors high
  assign stat_byte = {sticky_q, st_tx_emt, st_tx_rdy, st_full, st_rx_rdy};

  assign data_bits = fmt1_q[1:0];
  assign par_en    = ~fmt1_q[4];
  assign par_odd   = fmt1_q[2];
  assign stop_two  = fmt2_q[3];

  always_comb begin
    case (ptr_q)
      PTR_EXT:  mode_view = ext_cfg;
      PTR_FMT1: mode_view = fmt1_q;
      default:  mode_view = fmt2_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en    <= 1'b0;
      tx_en    <= 1'b0;
      rx_rst   <= 1'b0;
      tx_rst   <= 1'b0;
      brk_on   <= 1'b0;
      brk_chg  <= 1'b0;
      ptr_q    <= PTR_FMT1;
      ext_cfg  <= '0;
      fmt1_q   <= FMT1_RESET;
      fmt2_q   <= FMT2_RESET;
      sticky_q <= '0;
      clk_sel  <= '0;
      tx_data  <= '0;
      tx_push  <= 1'b0;
      rx_pop   <= 1'b0;
    end else begin
      rx_rst  <= wr_cmd && (nib == CMD_RX_RST);
      tx_rst  <= wr_cmd && (nib == CMD_TX_RST);
      tx_push <= wr_hold;
      rx_pop  <= rd_hold;
      if (wr_hold) tx_data <= wdata;
      if (wr_stat) clk_sel <= wdata;

      if (wr_cmd) begin
        // disable and reset dominate enable
        if (wdata[1] || (nib == CMD_RX_RST))      rx_en <= 1'b0;
        else if (wdata[0])                        rx_en <= 1'b1;
        if (wdata[3] || (nib == CMD_TX_RST))      tx_en <= 1'b0;
        else if (wdata[2])                        tx_en <= 1'b1;
        if (nib == CMD_BRK_ON)                    brk_on <= 1'b1;
        else if (nib == CMD_BRK_OFF)              brk_on <= 1'b0;
      end

      // a new event outranks a clear in the same cycle
      sticky_q <= (clr_err ? sticky_t'('0) : sticky_q) | sticky_set;
      brk_chg  <= (clr_bchg ? 1'b0 : brk_chg) | ev_brk_chg;

      if (ptr_to_fmt) begin
        ptr_q <= PTR_FMT1;
      end else if (ptr_to_ext) begin
        ptr_q <= PTR_EXT;
      end else if (wr_mode) begin
        case (ptr_q)
          PTR_EXT: begin
            ext_cfg <= wdata;
            ptr_q   <= PTR_FMT1;
          end
          PTR_FMT1: begin
            fmt1_q <= wdata;
            ptr_q  <= PTR_FMT2;
          end
          default: fmt2_q <= wdata;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rf_rdmux.sv
module uart_rf_rdmux import uart_rf_pkg::*; #(
  parameter int NUM_CH = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + OFF_W,
  localparam int FLAT_W = BYTE_W * NUM_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [FLAT_W-1:0] stat_flat,
  input  logic [FLAT_W-1:0] mode_flat,
  input  logic [FLAT_W-1:0] rxd_flat,
  output logic [BYTE_W-1:0] bus_rdata
);
  logic [BYTE_W-1:0] sel_byte;
  int                ch_idx;

  assign ch_idx = int'(bus_addr[ADDR_W-1:OFF_W]);

  always_comb begin
    sel_byte = '0;
    if (ch_idx < NUM_CH) begin
      case (bus_addr[OFF_W-1:0])
        OFF_MODE: sel_byte = mode_flat[ch_idx*BYTE_W +: BYTE_W];
        OFF_STAT: sel_byte = stat_flat[ch_idx*BYTE_W +: BYTE_W];
        OFF_HOLD: sel_byte = rxd_flat[ch_idx*BYTE_W +: BYTE_W];
        default:  sel_byte = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= sel_byte;
  end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront import uart_rf_pkg::*; #(
  parameter int NUM_CH   = 2,
  parameter bit EXT_MODE = 1'b1,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W  = CH_W + OFF_W,
  localparam int FLAT_W  = BYTE_W * NUM_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] st_rx_rdy,
  input  logic [NUM_CH-1:0] st_full,
  input  logic [NUM_CH-1:0] st_tx_rdy,
  input  logic [NUM_CH-1:0] st_tx_emt,
  input  logic [NUM_CH-1:0] ev_ovr,
  input  logic [NUM_CH-1:0] ev_par,
  input  logic [NUM_CH-1:0] ev_frm,
  input  logic [NUM_CH-1:0] ev_brk,
  input  logic [NUM_CH-1:0] ev_brk_chg,
  input  logic [FLAT_W-1:0] rx_data,
  output logic [NUM_CH-1:0] rx_en,
  output logic [NUM_CH-1:0] tx_en,
  output logic [NUM_CH-1:0] rx_rst,
  output logic [NUM_CH-1:0] tx_rst,
  output logic [NUM_CH-1:0] brk_on,
  output logic [NUM_CH-1:0] brk_chg,
  output logic [2*NUM_CH-1:0] data_bits,
  output logic [NUM_CH-1:0] par_en,
  output logic [NUM_CH-1:0] par_odd,
  output logic [NUM_CH-1:0] stop_two,
  output logic [FLAT_W-1:0] ext_cfg,
  output logic [FLAT_W-1:0] clk_sel,
  output logic [FLAT_W-1:0] tx_data,
  output logic [NUM_CH-1:0] tx_push,
  output logic [NUM_CH-1:0] rx_pop
);
  logic [NUM_CH-1:0] wr_mode, wr_stat, wr_cmd, wr_hold, rd_hold;
  logic [FLAT_W-1:0] stat_flat, mode_flat;

  uart_rf_decode #(.NUM_CH(NUM_CH)) u_dec (
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .bus_addr (bus_addr),
    .wr_mode  (wr_mode),
    .wr_stat  (wr_stat),
    .wr_cmd   (wr_cmd),
    .wr_hold  (wr_hold),
    .rd_hold  (rd_hold)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    uart_rf_chan #(.EXT_MODE(EXT_MODE)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .wr_mode    (wr_mode[c]),
      .wr_stat    (wr_stat[c]),
      .wr_cmd     (wr_cmd[c]),
      .wr_hold    (wr_hold[c]),
      .rd_hold    (rd_hold[c]),
      .wdata      (bus_wdata),
      .st_rx_rdy  (st_rx_rdy[c]),
      .st_full    (st_full[c]),
      .st_tx_rdy  (st_tx_rdy[c]),
      .st_tx_emt  (st_tx_emt[c]),
      .ev_ovr     (ev_ovr[c]),
      .ev_par     (ev_par[c]),
      .ev_frm     (ev_frm[c]),
      .ev_brk     (ev_brk[c]),
      .ev_brk_chg (ev_brk_chg[c]),
      .rx_en      (rx_en[c]),
      .tx_en      (tx_en[c]),
      .rx_rst     (rx_rst[c]),
      .tx_rst     (tx_rst[c]),
      .brk_on     (brk_on[c]),
      .brk_chg    (brk_chg[c]),
      .data_bits  (data_bits[2*c +: 2]),
      .par_en     (par_en[c]),
      .par_odd    (par_odd[c]),
      .stop_two   (stop_two[c]),
      .ext_cfg    (ext_cfg[BYTE_W*c +: BYTE_W]),
      .clk_sel    (clk_sel[BYTE_W*c +: BYTE_W]),
      .tx_data    (tx_data[BYTE_W*c +: BYTE_W]),
      .tx_push    (tx_push[c]),
      .rx_pop     (rx_pop[c]),
      .stat_byte  (stat_flat[BYTE_W*c +: BYTE_W]),
      .mode_view  (mode_flat[BYTE_W*c +: BYTE_W])
    );
  end

  uart_rf_rdmux #(.NUM_CH(NUM_CH)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .stat_flat (stat_flat),
    .mode_flat (mode_flat),
    .rxd_flat  (rx_data),
    .bus_rdata (bus_rdata)
  );
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
  parameter int NUM_CH  = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic              bus_re,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [NUM_CH-1:0] rx_en,
  input logic [NUM_CH-1:0] tx_en,
  input logic [NUM_CH-1:0] rx_rst,
  input logic [NUM_CH-1:0] tx_rst,
  input logic [NUM_CH-1:0] brk_on,
  input logic [NUM_CH-1:0] stop_two,
  input logic [8*NUM_CH-1:0] tx_data,
  input logic [NUM_CH-1:0] tx_push,
  input logic [NUM_CH-1:0] rx_pop
);
  // R1
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr[2]) |=> ($stable(rx_en) && $stable(tx_en) && $stable(brk_on) && $stable(stop_two)));

  // R8
  fmt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> $stable(stop_two));

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_c
    localparam logic [ADDR_W-1:0] HOLD_A = ADDR_W'(i*8 + 3);
    localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(i*8 + 2);

    // R3
    rx_reset_off_chk: assert property (@(posedge clk) disable iff (rst)
      rx_rst[i] |-> !rx_en[i]);

    // R3
    tx_reset_off_chk: assert property (@(posedge clk) disable iff (rst)
      tx_rst[i] |-> !tx_en[i]);

    // R4
    break_start_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == CMD_A && bus_wdata[7:4] == 4'h6) |=> brk_on[i]);

    // R11
    push_load_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == HOLD_A) |=> (tx_push[i] && tx_data[8*i +: 8] == $past(bus_wdata)));

    // R11
    push_cause_chk: assert property (@(posedge clk) disable iff (rst)
      tx_push[i] |-> ($past(bus_we) && $past(bus_addr) == HOLD_A));

    // R11
    pop_cause_chk: assert property (@(posedge clk) disable iff (rst)
      rx_pop[i] |-> ($past(bus_re) && $past(bus_addr) == HOLD_A));
  end
endmodule

bind uart_regfront uart_regfront_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/uart_regfront_test.sv
`timescale 1ns/1ps
module uart_regfront_test;
  localparam int NCH = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, bus_we, bus_re;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [NCH-1:0] st_rx_rdy, st_full, st_tx_rdy, st_tx_emt;
  logic [NCH-1:0] ev_ovr, ev_par, ev_frm, ev_brk, ev_brk_chg;
  logic [8*NCH-1:0] rx_data;

  logic [7:0] bus_rdata, b_rdata;
  logic [NCH-1:0] rx_en, tx_en, rx_rst, tx_rst, brk_on, brk_chg, par_en, par_odd, stop_two, tx_push, rx_pop;
  logic [NCH-1:0] b_rx_en, b_tx_en, b_rx_rst, b_tx_rst, b_brk_on, b_brk_chg, b_par_en, b_par_odd, b_stop_two, b_tx_push, b_rx_pop;
  logic [2*NCH-1:0] data_bits, b_data_bits;
  logic [8*NCH-1:0] ext_cfg, clk_sel, tx_data, b_ext_cfg, b_clk_sel, b_tx_data;

  uart_regfront #(.NUM_CH(NCH), .EXT_MODE(1'b1)) uut (
    .clk, .rst, .bus_we, .bus_re, .bus_addr, .bus_wdata, .bus_rdata,
    .st_rx_rdy, .st_full, .st_tx_rdy, .st_tx_emt,
    .ev_ovr, .ev_par, .ev_frm, .ev_brk, .ev_brk_chg, .rx_data,
    .rx_en, .tx_en, .rx_rst, .tx_rst, .brk_on, .brk_chg,
    .data_bits, .par_en, .par_odd, .stop_two,
    .ext_cfg, .clk_sel, .tx_data, .tx_push, .rx_pop
  );

  uart_regfront #(.NUM_CH(NCH), .EXT_MODE(1'b0)) uut_base (
    .clk, .rst, .bus_we, .bus_re, .bus_addr, .bus_wdata, .bus_rdata(b_rdata),
    .st_rx_rdy, .st_full, .st_tx_rdy, .st_tx_emt,
    .ev_ovr, .ev_par, .ev_frm, .ev_brk, .ev_brk_chg, .rx_data,
    .rx_en(b_rx_en), .tx_en(b_tx_en), .rx_rst(b_rx_rst), .tx_rst(b_tx_rst),
    .brk_on(b_brk_on), .brk_chg(b_brk_chg), .data_bits(b_data_bits),
    .par_en(b_par_en), .par_odd(b_par_odd), .stop_two(b_stop_two),
    .ext_cfg(b_ext_cfg), .clk_sel(b_clk_sel), .tx_data(b_tx_data),
    .tx_push(b_tx_push), .rx_pop(b_rx_pop)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic m_rx, m_tx, m_brk;
    logic [3:0] n;
    logic [3:0] c;
    logic [31:0] snap;

    rst = 1'b1; bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0;
    st_rx_rdy = '0; st_full = '0; st_tx_rdy = '0; st_tx_emt = '0;
    ev_ovr = '0; ev_par = '0; ev_frm = '0; ev_brk = '0; ev_brk_chg = '0;
    rx_data = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state: R2 R7 R8 R12
    check("R2 reset enables", {rx_en, tx_en, brk_on}, '0);
    check("R7 reset format", {data_bits, par_en}, {4'b1111, 2'b00});
    check("R8 reset stop", stop_two, 2'b00);
    check("R12 reset clock select", clk_sel, '0);

    // full command byte sweep on channel 0: R2 R3 R4 R1
    m_rx = 1'b0; m_tx = 1'b0; m_brk = 1'b0;
    for (int v = 0; v < 256; v++) begin
      n = 4'(v >> 4);
      wr(4'd2, 8'(v));
      if (v[1] || n == 4'd2) m_rx = 1'b0; else if (v[0]) m_rx = 1'b1;
      if (v[3] || n == 4'd3) m_tx = 1'b0; else if (v[2]) m_tx = 1'b1;
      if (n == 4'd6) m_brk = 1'b1; else if (n == 4'd7) m_brk = 1'b0;
      check("R2 R3 R4 command sweep", {rx_en[0], tx_en[0], brk_on[0], rx_rst[0], tx_rst[0]},
            {m_rx, m_tx, m_brk, n == 4'd2, n == 4'd3});
      check("R1 channel isolation", {rx_en[1], tx_en[1], brk_on[1], rx_rst[1], tx_rst[1]}, '0);
    end

    // mode pointer walk on channel 1: R5 R7 R8
    wr(4'd8, 8'h01);
    check("R5 reset pointer at first format", data_bits[3:2], 2'd1);
    wr(4'd10, 8'h10);
    wr(4'd8, 8'h02);
    check("R7 seven bits even", {data_bits[3:2], par_en[1], par_odd[1]}, {2'd2, 1'b1, 1'b0});
    rd(4'd8, d);
    check("R5 read under pointer", d, 8'h07);
    wr(4'd8, 8'h0F);
    check("R8 two stop bits", {stop_two[1], data_bits[3:2]}, {1'b1, 2'd2});
    wr(4'd8, 8'h07);
    check("R5 pointer stays on second", {stop_two[1], data_bits[3:2]}, {1'b0, 2'd2});
    wr(4'd10, 8'h10);
    rd(4'd8, d);
    check("R5 repoint first format", d, 8'h02);
    rd(4'd8, d);
    check("R5 read does not advance", d, 8'h02);

    // first format register sweep on channel 0: R7
    for (int v = 0; v < 32; v++) begin
      wr(4'd2, 8'h10);
      wr(4'd0, 8'(v));
      check("R7 format decode", {data_bits[1:0], par_en[0], par_odd[0]},
            {2'(v), ~v[4], v[2]});
    end

    // extended byte pointer: R6
    wr(4'd2, 8'hB0);
    wr(4'd0, 8'hA5);
    check("R6 extended byte loaded", ext_cfg[7:0], 8'hA5);
    check("R6 no pointer in base variant", b_stop_two[0], 1'b0);
    wr(4'd0, 8'h00);
    check("R6 then first format", {data_bits[1:0], par_en[0]}, {2'd0, 1'b1});
    wr(4'd0, 8'h0F);
    check("R6 then second format", stop_two[0], 1'b1);
    check("R6 base extended untouched", {b_ext_cfg[7:0], b_data_bits[1:0], b_stop_two[0]},
          {8'h00, 2'd3, 1'b1});

    // status live bits: R9
    wr(4'd2, 8'h40);
    for (int v = 0; v < 16; v++) begin
      c = 4'(v);
      {st_tx_emt[0], st_tx_rdy[0], st_full[0], st_rx_rdy[0]} = c;
      rd(4'd1, d);
      check("R9 live status bits", d, {4'h0, c});
    end
    c = 4'b0101;
    {st_tx_emt[0], st_tx_rdy[0], st_full[0], st_rx_rdy[0]} = c;
    // sticky error bits: R9 R10
    for (int v = 0; v < 16; v++) begin
      wr(4'd2, 8'h40);
      {ev_brk[0], ev_frm[0], ev_par[0], ev_ovr[0]} = 4'(v);
      @(negedge clk);
      {ev_brk[0], ev_frm[0], ev_par[0], ev_ovr[0]} = 4'h0;
      rd(4'd1, d);
      check("R9 sticky error bits", d, {4'(v), c});
    end
    wr(4'd2, 8'h40);
    rd(4'd1, d);
    check("R10 clear keeps ready bits", d, {4'h0, c});
    ev_ovr[0] = 1'b1;
    wr(4'd2, 8'h40);
    ev_ovr[0] = 1'b0;
    rd(4'd1, d);
    check("R10 event beats clear", d, {4'b0001, c});
    rd(4'd9, d);
    check("R1 other channel status", d, 8'h00);
    ev_brk_chg[0] = 1'b1;
    @(negedge clk);
    ev_brk_chg[0] = 1'b0;
    check("R10 break change set", brk_chg, 2'b01);
    wr(4'd2, 8'h50);
    check("R10 break change cleared", brk_chg, 2'b00);

    // holding register: R11 R13
    rx_data = 16'h3C00;
    rd(4'd11, d);
    check("R11 holding read data", d, 8'h3C);
    check("R11 pop pulse", rx_pop, 2'b10);
    @(negedge clk);
    check("R11 pop one cycle", rx_pop, 2'b00);
    rx_data = 16'h1100;
    repeat (2) @(negedge clk);
    check("R13 read data held", bus_rdata, 8'h3C);
    wr(4'd3, 8'h96);
    check("R11 push pulse and data", {tx_push, tx_data[7:0]}, {2'b01, 8'h96});
    @(negedge clk);
    check("R11 push one cycle", tx_push, 2'b00);

    // clock select: R12
    wr(4'd9, 8'h66);
    check("R12 clock select store", clk_sel, 16'h6600);

    // unmapped offsets: R1
    wr(4'd2, 8'h05);
    snap = {rx_en, tx_en, brk_on, stop_two, clk_sel, ext_cfg[7:0]};
    for (int a = 4; a < 16; a++) begin
      if ((a & 4) != 0) wr(4'(a), 8'hFF);
    end
    check("R1 unmapped writes ignored", {rx_en, tx_en, brk_on, stop_two, clk_sel, ext_cfg[7:0]}, snap);
    rd(4'd5, d);
    check("R1 unmapped read zero", d, 8'h00);
    rd(4'd2, d);
    check("R1 command read zero", d, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule